// File: doc/BRIEF.md
# One-Wire Byte Writer with One-Shot Strong Pullup

This block sits above a one-wire slot engine and transfers one byte at a time. It makes one slot request per bit, least-significant bit first. In write mode it drives the byte onto the bus. In touch mode it also collects the level the engine sampled in each slot and returns it as the received byte. The slot engine handles all bus timing. This block only sequences the slots, waits for each slot's acknowledge and tracks which bit is current.

Software can load a strong-pullup duration, in milliseconds, before a byte. The request applies to the next byte only. If the pullup is enabled, the pullup output goes high during the eighth slot, once that slot's low phase is over. It stays high for the programmed number of milliseconds after the byte. If the pullup is disabled, the block waits for the same interval without driving the pullup. In both cases the pending duration returns to zero. The done pulse marks the end of the whole operation, including any wait.

Top module: `owb_byte_writer`

## Requirements
- R1: Slots are requested one per bit with `slot_go`. The bit offered in slot i is `tx_byte[i]`, for i running from 0 to 7.
- R2: In touch mode (`touch`=1) the result has the sample of slot i at bit position i. In write mode `rx_byte` reads 8'h00.
- R3: The pullup output rises only during the slot of bit 7, and only after `slot_low` has dropped in that slot. It is never high while `slot_low` is high.
- R4: With an enabled, nonzero request, `spu_out` rises on the first cycle after bit 7's low phase. It stays high until the hold ends, which is exactly duration × CLK_PER_MS cycles after the last acknowledge.
- R5: A request is used by one byte only. The following byte gets no hold and no pullup.
- R6: With the pullup disabled, a pending request still delays done by the full interval, and `spu_out` stays low.
- R7: Loading a duration of zero cancels a pending request.
- R8: `done` is a one-cycle pulse. It comes one cycle after the final acknowledge when nothing is pending, and one cycle after the hold otherwise. `spu_out` is low while `done` is high.
- R9: `start` and `pu_load` are ignored while an operation is in progress.
- R10: After reset `done`, `slot_go` and `spu_out` are low and no request is pending.

Because the `rx_byte` encoding and the hold length are set out in R2 and R4, the bench can predict every output cycle from these lines alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pu_load | input | 1 | Load `pu_ms` as the pending pullup duration (idle only) |
| pu_ms | input | DUR_W | Pullup duration in milliseconds; zero cancels |
| pu_en | input | 1 | Strong pullup allowed to drive |
| start | input | 1 | Begin a byte (idle only) |
| touch | input | 1 | 1 = touch (return samples), 0 = write |
| tx_byte | input | 8 | Byte to send |
| rx_byte | output | 8 | Sampled byte (touch) or zero (write) |
| done | output | 1 | One-cycle end-of-operation pulse |
| slot_go | output | 1 | One-cycle request for one bit slot |
| slot_val | output | 1 | Bit value for the requested slot |
| slot_ack | input | 1 | Slot engine finished the slot |
| slot_sample | input | 1 | Level sampled in that slot, valid with `slot_ack` |
| slot_low | input | 1 | Slot engine is pulling the bus low |
| spu_out | output | 1 | Strong pullup drive |

## Verification
The first `slot_go` is visible one cycle after `start` is sampled, and each later one comes one cycle after the previous acknowledge. `spu_out` follows the cycle after the eighth slot's low phase ends. `done` comes one cycle after the last acknowledge, plus duration × CLK_PER_MS cycles when a request is pending. The bench's slot model fixes the low and acknowledge offsets for every slot. From those offsets it computes the expected cycle windows for `spu_out` and `done`. It then compares both outputs against the windows on every falling edge. `rx_byte` is read in the cycle `done` is high.

// File: rtl/owb_pkg.sv
package owb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_HOLD,
    ST_DONE
  } owb_state_e;

  // bit offered in slot i of a byte
  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] i);
    return b[i];
  endfunction

  // drop a sampled level into position i of the accumulated byte
  function automatic logic [7:0] place_bit(input logic [7:0] acc, input logic [2:0] i,
                                           input logic s);
    logic [7:0] r;
    r    = acc;
    r[i] = s;
    return r;
  endfunction

endpackage

// File: rtl/owb_bit_seq.sv
module owb_bit_seq
  import owb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] tx_in,
  input  logic       step,
  input  logic       sample,
  output logic [2:0] idx,
  output logic       cur_bit,
  output logic [7:0] rx,
  output logic       last
);

  logic [7:0] tx_q;
  logic [2:0] idx_q;
  logic [7:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      idx_q <= '0;
      rx_q  <= '0;
    end else if (load) begin
      tx_q  <= tx_in;
      idx_q <= '0;
      rx_q  <= '0;
    end else if (step) begin
      rx_q <= place_bit(rx_q, idx_q, sample);
      if (idx_q != 3'd7) idx_q <= idx_q + 3'd1;
    end
  end

  assign idx     = idx_q;
  assign cur_bit = pick_bit(tx_q, idx_q);
  assign rx      = rx_q;
  assign last    = (idx_q == 3'd7);

endmodule

// File: rtl/owb_ms_timer.sv
module owb_ms_timer #(
  parameter int MS_W       = 8,
  parameter int CLK_PER_MS = 250000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [MS_W-1:0] ms,
  output logic            active,
  output logic            fin
);

  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0]   cyc_q;
  logic [MS_W-1:0] ms_left_q;
  logic            act_q;

  assign fin    = act_q && (cyc_q == CYC_LAST) && (ms_left_q == MS_W'(1));
  assign active = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q     <= '0;
      ms_left_q <= '0;
      act_q     <= 1'b0;
    end else if (go) begin
      cyc_q     <= '0;
      ms_left_q <= ms;
      act_q     <= (ms != '0);
    end else if (act_q) begin
      if (cyc_q == CYC_LAST) begin
        cyc_q <= '0;
        if (ms_left_q == MS_W'(1)) act_q <= 1'b0;
        ms_left_q <= ms_left_q - MS_W'(1);
      end else begin
        cyc_q <= cyc_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/owb_byte_writer.sv
module owb_byte_writer
  import owb_pkg::*;
#(
  parameter int DUR_W      = 8,
  parameter int CLK_PER_MS = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pu_load,
  input  logic [DUR_W-1:0] pu_ms,
  input  logic             pu_en,
  input  logic             start,
  input  logic             touch,
  input  logic [7:0]       tx_byte,
  output logic [7:0]       rx_byte,
  output logic             done,
  output logic             slot_go,
  output logic             slot_val,
  input  logic             slot_ack,
  input  logic             slot_sample,
  input  logic             slot_low,
  output logic             spu_out
);

  owb_state_e       st_q;
  logic [DUR_W-1:0] pend_q;
  logic             touch_q, armed_q, low_seen_q, spu_q, spu_d;

  logic [2:0] bit_idx;
  logic       cur_bit, last_bit;
  logic [7:0] rx_sh;

  logic hold_go, hold_fin, hold_active;

  // named events for the checker
  logic idle, accept, in_hold, slot_done_ev, low_over;
  assign idle         = (st_q == ST_IDLE);
  assign accept       = idle && start;
  assign in_hold      = (st_q == ST_HOLD);
  assign slot_done_ev = (st_q == ST_WAIT) && slot_ack;
  assign low_over     = low_seen_q && !slot_low;
  assign hold_go      = slot_done_ev && last_bit && (pend_q != '0);

  owb_bit_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .tx_in   (tx_byte),
    .step    (slot_done_ev),
    .sample  (slot_sample),
    .idx     (bit_idx),
    .cur_bit (cur_bit),
    .rx      (rx_sh),
    .last    (last_bit)
  );

  owb_ms_timer #(.MS_W(DUR_W), .CLK_PER_MS(CLK_PER_MS)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (hold_go),
    .ms     (pend_q),
    .active (hold_active),
    .fin    (hold_fin)
  );

  always_comb begin
    spu_d = 1'b0;
    case (st_q)
      ST_WAIT: spu_d = armed_q && last_bit && low_over;
      ST_HOLD: spu_d = armed_q && !hold_fin;
      default: spu_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pend_q     <= '0;
      touch_q    <= 1'b0;
      armed_q    <= 1'b0;
      low_seen_q <= 1'b0;
      spu_q      <= 1'b0;
    end else begin
      spu_q <= spu_d;
      case (st_q)
        ST_IDLE: begin
          if (pu_load) pend_q <= pu_ms;
          if (start) begin
            touch_q <= touch;
            st_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          low_seen_q <= slot_low;
          if (last_bit) armed_q <= pu_en && (pend_q != '0);
          st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          low_seen_q <= low_seen_q | slot_low;
          if (slot_ack) begin
            if (!last_bit)    st_q <= ST_ISSUE;
            else if (hold_go) st_q <= ST_HOLD;
            else              st_q <= ST_DONE;
          end
        end
        ST_HOLD: begin
          if (hold_fin) begin
            pend_q <= '0;
            st_q   <= ST_DONE;
          end
        end
        ST_DONE: begin
          armed_q <= 1'b0;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign slot_go  = (st_q == ST_ISSUE);
  assign slot_val = cur_bit;
  assign done     = (st_q == ST_DONE);
  assign rx_byte  = touch_q ? rx_sh : 8'h00;
  assign spu_out  = spu_q;

endmodule

// File: rtl/owb_checker.sv
module owb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_go,
  input logic       slot_low,
  input logic       spu_out,
  input logic       done,
  input logic [2:0] bit_idx,
  input logic       in_hold,
  input logic       hold_active,
  input logic       hold_fin
);

  // R3
  no_pullup_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spu_out && slot_low));

  // R3
  pullup_last_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spu_out) |-> (bit_idx == 3'd7));

  // R4
  hold_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fin |=> (done && !spu_out));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  no_done_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_hold |-> (!done && hold_active));

  // R1
  slot_go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_go |=> !slot_go);

endmodule

bind owb_byte_writer owb_checker u_owb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .slot_go     (slot_go),
  .slot_low    (slot_low),
  .spu_out     (spu_out),
  .done        (done),
  .bit_idx     (bit_idx),
  .in_hold     (in_hold),
  .hold_active (hold_active),
  .hold_fin    (hold_fin)
);

// File: tb/owb_byte_writer_tb.sv
module owb_byte_writer_tb_top;

  localparam int DW = 8;
  localparam int K  = 4;
  localparam int ACK_OFS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pu_load = 1'b0;
  logic [DW-1:0] pu_ms = '0;
  logic pu_en = 1'b0;
  logic start = 1'b0;
  logic touch = 1'b0;
  logic [7:0] tx_byte = '0;
  logic [7:0] rx_byte;
  logic done, slot_go, slot_val, spu_out;
  logic slot_ack = 1'b0;
  logic slot_sample = 1'b0;
  logic slot_low = 1'b0;

  always #2 clk = ~clk;

  owb_byte_writer #(.DUR_W(DW), .CLK_PER_MS(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .pu_load(pu_load), .pu_ms(pu_ms), .pu_en(pu_en),
    .start(start), .touch(touch), .tx_byte(tx_byte), .rx_byte(rx_byte),
    .done(done), .slot_go(slot_go), .slot_val(slot_val), .slot_ack(slot_ack),
    .slot_sample(slot_sample), .slot_low(slot_low), .spu_out(spu_out)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit run_on = 1'b0;

  // behavioural model state
  logic [7:0] cur_tx, cur_dev;
  int nbit = 0;
  int mdl_pend = 0;
  bit mdl_en = 1'b0;
  int done_at = -1;
  int spu_lo = 1, spu_hi = 0;
  int low_end = -1, ack_at = -1;
  logic smp = 1'b0;
  bit seen_done = 1'b0;
  logic [7:0] rx_cap;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // slot engine model and per-cycle comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (run_on) begin
        chk(done == (cyc == done_at), "R8 done timing", done, cyc == done_at);
        chk(spu_out == (cyc >= spu_lo && cyc <= spu_hi), "R4 spu_out window",
            spu_out, cyc >= spu_lo && cyc <= spu_hi);
        if (done) begin
          seen_done = 1'b1;
          rx_cap = rx_byte;
        end
        slot_ack = 1'b0;
        if (cyc == low_end) slot_low = 1'b0;
        if (cyc == ack_at) begin
          slot_ack = 1'b1;
          slot_sample = smp;
        end
        if (slot_go) begin
          if (nbit > 7) begin
            chk(1'b0, "R9 unexpected slot", nbit, 8);
          end else begin
            chk(slot_val == cur_tx[nbit], "R1 slot bit order", slot_val, cur_tx[nbit]);
            slot_low = 1'b1;
            low_end = cyc + (slot_val ? 1 : 2);
            ack_at = cyc + ACK_OFS;
            smp = slot_val & cur_dev[nbit];
            if (nbit == 7) begin
              if (mdl_pend != 0 && mdl_en) begin
                spu_lo = low_end + 1;
                spu_hi = ack_at + mdl_pend * K;
              end
              done_at = ack_at + mdl_pend * K + 1;
              mdl_pend = 0;
            end
          end
          nbit++;
        end
      end
    end
  end

  task automatic load_pu(input int ms);
    @(negedge clk);
    pu_load = 1'b1;
    pu_ms = DW'(ms);
    mdl_pend = ms;
    @(negedge clk);
    pu_load = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] tx, input logic [7:0] dv, input bit tch,
                         input bit poke, input string req);
    cur_tx = tx; cur_dev = dv; nbit = 0; seen_done = 1'b0;
    spu_lo = 1; spu_hi = 0; done_at = -1;
    @(negedge clk);
    tx_byte = tx; touch = tch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 3000 && !seen_done; i++) begin
      if (poke && i == 10) begin
        start = 1'b1; pu_load = 1'b1; pu_ms = DW'(7);
      end else begin
        start = 1'b0; pu_load = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; pu_load = 1'b0;
    chk(seen_done, {req, " done seen"}, seen_done, 1);
    chk(rx_cap == (tch ? (tx & dv) : 8'h00), {req, " rx_byte"}, rx_cap,
        tch ? (tx & dv) : 8'h00);
    chk(nbit == 8, {req, " slot count"}, nbit, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 done low", done, 0);
    chk(slot_go == 1'b0, "R10 slot_go low", slot_go, 0);
    chk(spu_out == 1'b0, "R10 spu_out low", spu_out, 0);
    run_on = 1'b1;

    do_byte(8'hA5, 8'hFF, 1'b0, 1'b0, "R1 R2 R10 write");
    do_byte(8'hFF, 8'h3C, 1'b1, 1'b0, "R2 touch read");
    do_byte(8'h0F, 8'hFF, 1'b1, 1'b0, "R2 touch mixed");

    mdl_en = 1'b1; pu_en = 1'b1;
    load_pu(3);
    do_byte(8'h81, 8'hFF, 1'b0, 1'b0, "R3 R4 pullup bit7=1");
    do_byte(8'h5A, 8'hFF, 1'b0, 1'b0, "R5 one shot");
    load_pu(2);
    do_byte(8'h3C, 8'hF0, 1'b1, 1'b0, "R3 R4 pullup bit7=0");

    mdl_en = 1'b0; pu_en = 1'b0;
    load_pu(2);
    do_byte(8'hC3, 8'hFF, 1'b0, 1'b0, "R6 disabled wait");

    mdl_en = 1'b1; pu_en = 1'b1;
    load_pu(5);
    load_pu(0);
    do_byte(8'h96, 8'hFF, 1'b0, 1'b0, "R7 cancel");

    do_byte(8'h24, 8'hFF, 1'b0, 1'b1, "R9 busy inputs");
    repeat (12) @(negedge clk);
    chk(nbit == 8, "R9 no restart", nbit, 8);
    do_byte(8'h18, 8'hFF, 1'b0, 1'b0, "R9 load ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule